// File: doc/BRIEF.md
# Floating-Point Issue Gate and Completion Tracker

This block sits between instruction decode and a set of shared floating-point functional units. Each cycle it sees at most one operation request: a valid bit, a 3-bit operation code and a result tag. It tells the requester whether that operation may start now. Each unit class has its own latency and its own minimum spacing between starts. A started operation produces a one-cycle completion pulse, carrying the tag, exactly its latency later. The arithmetic itself is not computed here, only the timing of issue and completion.

The five unit classes are independent. A busy divider does not hold back an add, and results from different classes may complete in the same cycle. For that reason every class has its own completion pulse and tag field. A request that cannot start raises a stall. The requester keeps the request unchanged until it is taken.

Top module: `fpu_issue_tracker`

## Requirements
- R1: Operation codes are ADD=0, SUB=1, MUL=2, DIV=3, NEG=4, ABS=5, CMP=6. ADD and SUB share the add class, and NEG and ABS share the sign class. Code 7 is reserved: `req_ready` stays low for it and it starts nothing.
- R2: `req_ready` is combinational. It is high when the class of `req_op` has let its full start interval pass since its last start. An operation starts in a cycle where `req_valid` and `req_ready` are both high.
- R3: The add class (ADD, SUB) has a latency of 4 cycles and a start interval of 3 cycles.
- R4: The multiply class has a latency of 8 cycles and a start interval of 4 cycles.
- R5: The divide class has a latency of 36 cycles and a start interval of 35 cycles.
- R6: The sign class (NEG, ABS) has a latency of 2 cycles and a start interval of 1 cycle, so it accepts back-to-back starts.
- R7: The compare class has a latency of 3 cycles and a start interval of 2 cycles.
- R8: `res_valid` bit k is high for one cycle, exactly latency cycles after a start of class k. In that cycle `res_tag[k*TAG_W +: TAG_W]` holds the tag given at the start. The class index order is add=0, mul=1, div=2, sign=3, cmp=4.
- R9: `req_stall` equals `req_valid` with `req_ready` low. A stalled request changes no state and produces no result.
- R10: Classes do not block each other. Results of different classes may be valid in the same cycle.
- R11: After synchronous reset no result is pending and every class is ready.
- R12: A stalled request with a legal code is held with the same code and tag until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Operation request present |
| req_op | input | 3 | Operation code (R1) |
| req_tag | input | TAG_W | Tag returned with the result |
| req_ready | output | 1 | Class of `req_op` can start this cycle |
| req_stall | output | 1 | Request present but not accepted |
| res_valid | output | 5 | Per-class completion pulse |
| res_tag | output | 5*TAG_W | Per-class completion tag fields |

## Verification
`req_ready` and `req_stall` answer in the same cycle as the request, so the bench compares them against the reference model in the cycle where the request is driven. A completion is due in cycle issue+L, counted from the cycle the request was accepted. The model stores that due cycle with the tag and compares all five result bits and their tags on every cycle, so a pulse one cycle early or late, a duplicate pulse, or a wrong tag is caught. Inputs change just after the rising edge and outputs are sampled at the falling edge.

// File: rtl/fpit_pkg.sv
`timescale 1ns/1ps
// Shared codes and class mapping for the FP issue tracker.
// Assumes a 3-bit operation code; the class index order is fixed.
package fpit_pkg;

    localparam int NCLS = 5;

    localparam int CL_ADD = 0;
    localparam int CL_MUL = 1;
    localparam int CL_DIV = 2;
    localparam int CL_SGN = 3;
    localparam int CL_CMP = 4;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_MUL  = 3'd2,
        OP_DIV  = 3'd3,
        OP_NEG  = 3'd4,
        OP_ABS  = 3'd5,
        OP_CMP  = 3'd6,
        OP_RSVD = 3'd7
    } fp_op_e;

    // Map an operation code to a one-hot class vector (zero when reserved)
    function automatic logic [NCLS-1:0] op_class(input logic [2:0] op);
        logic [NCLS-1:0] s;
        s = '0;
        case (fp_op_e'(op))
            OP_ADD, OP_SUB: s[CL_ADD] = 1'b1;
            OP_MUL:         s[CL_MUL] = 1'b1;
            OP_DIV:         s[CL_DIV] = 1'b1;
            OP_NEG, OP_ABS: s[CL_SGN] = 1'b1;
            OP_CMP:         s[CL_CMP] = 1'b1;
            default:        s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fpit_decode.sv
`timescale 1ns/1ps
// Operation decoder: turns the request code into a one-hot class select
// and a legality flag. Purely combinational; assumes codes per fpit_pkg.
module fpit_decode
    import fpit_pkg::*;
(
    input  logic [2:0]      op,
    output logic [NCLS-1:0] sel,
    output logic            legal
);

    // Class lookup and legality of the code
    always_comb begin
        sel   = op_class(op);
        legal = (op != 3'(OP_RSVD));
    end

endmodule

// File: rtl/fpit_interval.sv
`timescale 1ns/1ps
// Start-interval counter for one unit class. On a start it loads II-1 and
// then counts down once per cycle; the class is free when it reads zero.
// Assumes II >= 1. With II == 1 no storage is built and the class is always free.
module fpit_interval #(
    parameter int II = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic free
);

    localparam int CW = (II > 1) ? $clog2(II) : 1;

    generate
        if (II == 1) begin : g_pipelined
            // Fully pipelined unit: a start is possible every cycle
            assign free = 1'b1;
        end else begin : g_counted
            logic [CW-1:0] cnt;

            // Load on start, otherwise count down to zero
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (start) begin
                    cnt <= CW'(II - 1);
                end else if (cnt != '0) begin
                    cnt <= cnt - 1'b1;
                end
            end

            assign free = (cnt == '0);
        end
    endgenerate

endmodule

// File: rtl/fpit_pending.sv
`timescale 1ns/1ps
// Pending-result tracker for one unit class: a LAT-deep delay line of
// valid/tag pairs. A push in cycle c appears at the output in cycle c+LAT.
// Assumes LAT >= 1; more than one result may be in flight at once.
module fpit_pending #(
    parameter int LAT   = 4,
    parameter int TAG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] tag_in,
    output logic             done,
    output logic [TAG_W-1:0] tag_out
);

    logic [LAT-1:0]   vld;
    logic [TAG_W-1:0] tg [LAT];

    generate
        if (LAT == 1) begin : g_single
            // One-stage line: capture the start directly
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld[0] <= 1'b0;
                    tg[0]  <= '0;
                end else begin
                    vld[0] <= push;
                    tg[0]  <= tag_in;
                end
            end
        end else begin : g_multi
            // Shift valid bits and tags one stage per cycle
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld <= '0;
                    for (int i = 0; i < LAT; i++) tg[i] <= '0;
                end else begin
                    vld <= {vld[LAT-2:0], push};
                    tg[0] <= tag_in;
                    for (int i = 1; i < LAT; i++) tg[i] <= tg[i-1];
                end
            end
        end
    endgenerate

    assign done    = vld[LAT-1];
    assign tag_out = tg[LAT-1];

endmodule

// File: rtl/fpu_issue_tracker.sv
`timescale 1ns/1ps
// FP issue gate and completion tracker. Decodes the request into a unit
// class and lets it start only when that class's interval counter is free.
// It then tracks the result through a per-class delay line.
// Assumes one request per cycle, held stable by the requester while stalled.
module fpu_issue_tracker
    import fpit_pkg::*;
#(
    parameter int TAG_W   = 4,
    parameter int LAT_ADD = 4,
    parameter int II_ADD  = 3,
    parameter int LAT_MUL = 8,
    parameter int II_MUL  = 4,
    parameter int LAT_DIV = 36,
    parameter int II_DIV  = 35,
    parameter int LAT_SGN = 2,
    parameter int II_SGN  = 1,
    parameter int LAT_CMP = 3,
    parameter int II_CMP  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [2:0]            req_op,
    input  logic [TAG_W-1:0]      req_tag,
    output logic                  req_ready,
    output logic                  req_stall,
    output logic [NCLS-1:0]       res_valid,
    output logic [NCLS*TAG_W-1:0] res_tag
);

    localparam int LAT_TBL [NCLS] = '{LAT_ADD, LAT_MUL, LAT_DIV, LAT_SGN, LAT_CMP};
    localparam int II_TBL  [NCLS] = '{II_ADD,  II_MUL,  II_DIV,  II_SGN,  II_CMP};

    logic [NCLS-1:0] sel;
    logic            legal;
    logic [NCLS-1:0] free;
    logic [NCLS-1:0] start;

    fpit_decode u_dec (
        .op    (req_op),
        .sel   (sel),
        .legal (legal)
    );

    // Issue decision: the selected class must be free
    always_comb begin
        req_ready = legal && ((sel & free) != '0);
        req_stall = req_valid && !req_ready;
        start     = (req_valid && req_ready) ? sel : '0;
    end

    genvar g;
    generate
        for (g = 0; g < NCLS; g++) begin : g_unit
            fpit_interval #(
                .II (II_TBL[g])
            ) u_ivl (
                .clk   (clk),
                .rst_n (rst_n),
                .start (start[g]),
                .free  (free[g])
            );

            fpit_pending #(
                .LAT   (LAT_TBL[g]),
                .TAG_W (TAG_W)
            ) u_pnd (
                .clk     (clk),
                .rst_n   (rst_n),
                .push    (start[g]),
                .tag_in  (req_tag),
                .done    (res_valid[g]),
                .tag_out (res_tag[g*TAG_W +: TAG_W])
            );
        end
    endgenerate

endmodule

// File: rtl/fpit_checker.sv
`timescale 1ns/1ps
// Property checker for fpu_issue_tracker, bound to every instance.
// It keeps its own up-counters of cycles since the last start and since
// the last result of each class.
module fpit_checker
    import fpit_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int II_ADD = 3,
    parameter int II_MUL = 4,
    parameter int II_DIV = 35,
    parameter int II_SGN = 1,
    parameter int II_CMP = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic [2:0]            req_op,
    input logic [TAG_W-1:0]      req_tag,
    input logic                  req_ready,
    input logic                  req_stall,
    input logic [NCLS-1:0]       res_valid,
    input logic [NCLS*TAG_W-1:0] res_tag
);

    localparam int II_TBL [NCLS] = '{II_ADD, II_MUL, II_DIV, II_SGN, II_CMP};
    localparam logic [15:0] SAT = 16'hFFFF;

    logic [NCLS-1:0] csel;
    logic [15:0]     since_acc [NCLS];
    logic [15:0]     since_res [NCLS];

    assign csel = op_class(req_op);

    // Ages of the last start and last result per class, saturating
    always_ff @(posedge clk) begin
        for (int k = 0; k < NCLS; k++) begin
            if (!rst_n) begin
                since_acc[k] <= SAT;
                since_res[k] <= SAT;
            end else begin
                if (req_valid && req_ready && csel[k]) since_acc[k] <= 16'd1;
                else if (since_acc[k] != SAT)          since_acc[k] <= since_acc[k] + 16'd1;
                if (res_valid[k])                      since_res[k] <= 16'd1;
                else if (since_res[k] != SAT)          since_res[k] <= since_res[k] + 16'd1;
            end
        end
    end

    AST_RSVD_NEVER_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == 3'(OP_RSVD)) |-> !req_ready); // R1

    AST_RESET_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (res_valid == '0)); // R11

    AST_STALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_stall && (req_op != 3'(OP_RSVD))) |-> (req_valid && $stable(req_op) && $stable(req_tag))); // R12

    genvar g;
    generate
        for (g = 0; g < NCLS; g++) begin : g_cls
            AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                (req_valid && req_ready && csel[g]) |-> (since_acc[g] >= 16'(II_TBL[g]))); // R2

            AST_RESULT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid[g] |-> (since_res[g] >= 16'(II_TBL[g]))); // R8
        end
    endgenerate

endmodule

bind fpu_issue_tracker fpit_checker #(
    .TAG_W  (TAG_W),
    .II_ADD (II_ADD),
    .II_MUL (II_MUL),
    .II_DIV (II_DIV),
    .II_SGN (II_SGN),
    .II_CMP (II_CMP)
) u_fpit_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_tag   (req_tag),
    .req_ready (req_ready),
    .req_stall (req_stall),
    .res_valid (res_valid),
    .res_tag   (res_tag)
);

// File: tb/fpu_issue_tracker_bench.sv
`timescale 1ns/1ps
// Bench for fpu_issue_tracker: a behavioural reference model with per-class
// "next allowed start" cycles and a queue of due results, compared every cycle.
module fpu_issue_tracker_bench;

    localparam int TAG_W = 4;
    localparam int NC    = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = 3'd0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              req_ready;
    logic              req_stall;
    logic [NC-1:0]     res_valid;
    logic [NC*TAG_W-1:0] res_tag;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    int coinc = 0;
    bit done  = 1'b0;
    int tagn  = 0;

    int    lat [NC] = '{4, 8, 36, 2, 3};
    int    ivl [NC] = '{3, 4, 35, 1, 2};
    string rq  [NC] = '{"R3", "R4", "R5", "R6", "R7"};
    int    next_ok [NC] = '{0, 0, 0, 0, 0};
    int    due_q [$];
    int    cls_q [$];
    int    tag_q [$];

    always #4 clk = ~clk; // 125 MHz

    fpu_issue_tracker u_fpu_issue_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_tag   (req_tag),
        .req_ready (req_ready),
        .req_stall (req_stall),
        .res_valid (res_valid),
        .res_tag   (res_tag)
    );

    function automatic int op_cls(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return 0;
            3'd2:       return 1;
            3'd3:       return 2;
            3'd4, 3'd5: return 3;
            3'd6:       return 4;
            default:    return -1;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    // One clock cycle: drive request, compare outputs at the falling edge, update model
    task automatic step(input bit v, input logic [2:0] op, input logic [TAG_W-1:0] tg, output bit acc);
        int c;
        bit er;
        logic [NC-1:0] ev;
        int et [NC];
        req_valid = v;
        req_op    = op;
        req_tag   = tg;
        @(negedge clk);
        c  = op_cls(op);
        er = (c >= 0) && (cyc >= next_ok[c]);
        // R2: readiness follows the class start interval
        chk(req_ready === er, (c < 0) ? "R1" : rq[c], "req_ready", int'(req_ready), int'(er));
        chk(req_stall === (v && !er), "R9", "req_stall", int'(req_stall), int'(v && !er));
        ev = '0;
        for (int k = 0; k < NC; k++) et[k] = 0;
        for (int i = due_q.size() - 1; i >= 0; i--) begin
            if (due_q[i] == cyc) begin
                ev[cls_q[i]] = 1'b1;
                et[cls_q[i]] = tag_q[i];
                due_q.delete(i); cls_q.delete(i); tag_q.delete(i);
            end
        end
        for (int k = 0; k < NC; k++) begin
            chk(res_valid[k] === ev[k], rq[k], "res_valid", int'(res_valid[k]), int'(ev[k]));
            if (ev[k])
                chk(res_tag[k*TAG_W +: TAG_W] === TAG_W'(et[k]), "R8", "res_tag",
                    int'(res_tag[k*TAG_W +: TAG_W]), et[k]);
        end
        if ($countones(ev) > 1) coinc++;
        acc = v && er;
        if (acc) begin
            due_q.push_back(cyc + lat[c]);
            cls_q.push_back(c);
            tag_q.push_back(int'(tg));
            next_ok[c] = cyc + ivl[c];
        end
        @(posedge clk);
        #1;
        cyc++;
    endtask

    // Issue one operation, holding it while stalled (R12)
    task automatic issue(input logic [2:0] op);
        bit acc;
        logic [TAG_W-1:0] tg;
        tg = TAG_W'(tagn);
        tagn++;
        acc = 1'b0;
        while (!acc) step(1'b1, op, tg, acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, acc);
    endtask

    initial begin
        bit acc;
        @(posedge clk); #1;
        @(posedge clk); #1;
        @(negedge clk);
        // R11: reset state
        chk(res_valid === '0, "R11", "res_valid in reset", int'(res_valid), 0);
        chk(req_ready === 1'b1, "R11", "ready in reset", int'(req_ready), 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        cyc   = 0;

        // R3: add then sub, sub held until the interval passes
        issue(3'd0); issue(3'd1); idle(8);
        // R4: multiply pair
        issue(3'd2); issue(3'd2); idle(12);
        // R5: divide pair
        issue(3'd3); issue(3'd3); idle(40);
        // R6: neg/abs back to back
        issue(3'd4); issue(3'd5); issue(3'd4); idle(4);
        // R7: compare pair
        issue(3'd6); issue(3'd6); idle(6);
        // R1: reserved code presented, then withdrawn
        for (int i = 0; i < 3; i++) step(1'b1, 3'd7, 4'hA, acc);
        idle(2);
        // R10: add then compare next cycle complete together; div busy meanwhile
        issue(3'd3); issue(3'd0); issue(3'd6); issue(3'd2); issue(3'd4);
        idle(40);
        chk(coinc > 0, "R10", "coincident results seen", coinc, 1);

        // Mixed traffic, stalled requests held
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 3) == 0) idle(1);
            else if ($urandom_range(0, 40) == 0) step(1'b1, 3'd7, '0, acc);
            else issue(3'($urandom_range(0, 6)));
        end
        idle(50);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog: actual cycle %0d expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule